// File: doc/BRIEF.md
# Framebuffer Line Pixel Unpacker

This block sits between a display controller's frame fetch and its colour pipeline. It takes the 32-bit words that make up one display line, accepted over a valid/ready handshake, and breaks them into pixels. It hands out one pixel per cycle over a second valid/ready handshake. A 3-bit depth code selects 1, 2, 4, 8, 16 or 32 bits per pixel. The three shallow depths and 8 bits give palette indices. 16 and 32 bits give direct RGB colour that is widened to 8 bits per component. Two ordering flags choose how pixels are placed inside a word, and a swap flag exchanges the red and blue fields of direct colours.

The line length is given as a column count. The block flags the last pixel of every line and drops whatever bits remain in the final word of that line, so every line starts on a fresh word. Two small helpers for the fetch side are combinational. The first reports the number of bytes a line occupies at the current depth. The second folds a frame base address from the upper memory alias into the lower half. Output happens only while both the enable and power controls are high. Dropping either one clears any partly consumed word and the line position.

Top module: `fb_line_unpack`

## Requirements
- R1: `depth_i` codes 0..5 mean 1, 2, 4, 8, 16 and 32 bits per pixel; codes 6 and 7 behave exactly as code 3. At depths up to 8 bits, `pix_o[7:0]` carries the index zero-extended from the pixel width, `pix_o[23:8]` is zero and `pix_direct_o` is 0.
- R2: `line_bytes_o` equals cols/8, cols/4, cols/2, cols, cols*2 and cols*4 for codes 0..5, with division truncating.
- R3: With both ordering flags clear, byte 0 (`word_i[7:0]`) is consumed first, then bytes 1..3 in turn. Inside a byte, the first pixel is taken from the lowest-order bits. A 16-bit pixel n is taken from bits [16n+15:16n].
- R4: With `pix_be_i`=1 and `byte_be_i`=0, the byte order stays as in R3, but inside each byte the first pixel is taken from the highest-order bits. At 8 bits or more this flag has no effect.
- R5: With `byte_be_i`=1, the four bytes of each word are reversed (byte 3 becomes byte 0) and pixels inside a byte are taken high-order first. `pix_be_i` is then ignored.
- R6: At 16 bits, a pixel p gives fields c0=p[4:0], c1=p[9:5] and c2=p[14:10]; p[15] is ignored. `pix_o` = {R,G,B}, each component being a field shifted left by 3, with G=c1. With `swap_rb_i`=0, R=c0 and B=c2; with `swap_rb_i`=1, R=c2 and B=c0. `pix_direct_o`=1.
- R7: At 32 bits, c0=p[7:0], c1=p[15:8] and c2=p[23:16], and p[31:24] is ignored. `pix_o` = {R,c1,B}, with R and B chosen by `swap_rb_i` as in R6. `pix_direct_o`=1.
- R8: `pix_last_o` is 1 exactly on pixel `cols_i`-1 of each line (`cols_i` >= 1). Bits left in that word are discarded, and the next line's first pixel comes from the next accepted word.
- R9: While `en_i` or `pwr_i` is 0, `word_ready_o` and `pix_valid_o` are 0, and any held word and the line position are discarded.
- R10: `base_o` = `base_i` - 0x8000_0000 when `base_i` > 0x8000_0000; otherwise `base_o` = `base_i`.
- R11: While `pix_valid_o`=1 and `pix_ready_i`=0, `pix_valid_o` stays 1, `pix_o` holds its value and no new word is accepted.
- R12: With `pix_ready_i` held at 1 and words always offered, pixels leave on consecutive cycles, including across word boundaries at 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable |
| pwr_i | input | 1 | Panel power enable |
| depth_i | input | 3 | Depth code |
| swap_rb_i | input | 1 | Exchange red and blue of direct colours |
| byte_be_i | input | 1 | Reverse bytes in a word (takes priority) |
| pix_be_i | input | 1 | First pixel in high bits of each byte |
| cols_i | input | COL_W | Pixels per line |
| base_i | input | ADDR_W | Frame base address as programmed |
| base_o | output | ADDR_W | Frame base address with alias removed |
| line_bytes_o | output | COL_W+2 | Bytes per line at current depth |
| word_i | input | 32 | Framebuffer word |
| word_valid_i | input | 1 | Word offered |
| word_ready_o | output | 1 | Word accepted when valid |
| pix_o | output | 24 | Palette index or {R,G,B} |
| pix_direct_o | output | 1 | `pix_o` is direct colour |
| pix_last_o | output | 1 | Last pixel of the line |
| pix_valid_o | output | 1 | Pixel available |
| pix_ready_i | input | 1 | Pixel taken when valid |

## Verification
The hardest case to reach is a line that ends part way through a word, with the next line's word accepted in the same cycle as the line's last pixel. That needs a column count that is not a multiple of the pixels per word, together with a source that never stalls. The bench uses 10 columns at 8 bits and offers words back to back, so the line end and a fresh word acceptance land in the same clock edge. A second hard case is dropping power while a pixel is held under back-pressure. The bench stalls the sink first, then clears `pwr_i` and checks that the old pixel does not come back.

// File: rtl/fbu_pkg.sv
`timescale 1ns/1ps
package fbu_pkg;

  localparam int WORD_W = 32;
  localparam int PIX_W  = 24;

  typedef enum logic [1:0] {
    ORD_LE      = 2'd0,
    ORD_PIX_HI  = 2'd1,
    ORD_BYTE_HI = 2'd2
  } order_e;

  // codes above 5 fold to 8 bits per pixel
  function automatic logic [2:0] norm_depth(input logic [2:0] d);
    return (d > 3'd5) ? 3'd3 : d;
  endfunction

  function automatic logic [5:0] bits_of(input logic [2:0] nd);
    case (nd)
      3'd0:    return 6'd1;
      3'd1:    return 6'd2;
      3'd2:    return 6'd4;
      3'd4:    return 6'd16;
      3'd5:    return 6'd32;
      default: return 6'd8;
    endcase
  endfunction

  function automatic logic [5:0] per_word(input logic [2:0] nd);
    case (nd)
      3'd0:    return 6'd32;
      3'd1:    return 6'd16;
      3'd2:    return 6'd8;
      3'd4:    return 6'd2;
      3'd5:    return 6'd1;
      default: return 6'd4;
    endcase
  endfunction

  // byte reversal beats pixel order
  function automatic order_e pick_order(input logic byte_be, input logic pix_be);
    if (byte_be)     return ORD_BYTE_HI;
    else if (pix_be) return ORD_PIX_HI;
    else             return ORD_LE;
  endfunction

  // reverse the order of sub-byte fields so the first pixel lands in the low bits
  function automatic logic [7:0] rev_fields(input logic [7:0] b, input logic [2:0] nd);
    logic [7:0] r;
    case (nd)
      3'd0: for (int i = 0; i < 8; i++) r[i] = b[7-i];
      3'd1: r = {b[1:0], b[3:2], b[5:4], b[7:6]};
      3'd2: r = {b[3:0], b[7:4]};
      default: r = b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fbu_line_geom.sv
`timescale 1ns/1ps
module fbu_line_geom #(
  parameter int COL_W  = 12,
  parameter int ADDR_W = 32
) (
  input  logic [COL_W-1:0]  cols_i,
  input  logic [2:0]        nd_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [COL_W+1:0]  line_bytes_o,
  output logic [ADDR_W-1:0] base_o
);
  localparam int LB_W = COL_W + 2;
  localparam logic [ADDR_W-1:0] ALIAS = ADDR_W'(1) << (ADDR_W - 1);

  logic [LB_W-1:0] cols_ext;
  assign cols_ext = LB_W'(cols_i);

  always_comb begin
    case (nd_i)
      3'd0:    line_bytes_o = cols_ext >> 3;
      3'd1:    line_bytes_o = cols_ext >> 2;
      3'd2:    line_bytes_o = cols_ext >> 1;
      3'd4:    line_bytes_o = cols_ext << 1;
      3'd5:    line_bytes_o = cols_ext << 2;
      default: line_bytes_o = cols_ext;
    endcase
  end

  assign base_o = (base_i > ALIAS) ? (base_i - ALIAS) : base_i;

  // R10
  always_comb begin
    base_not_grow_chk: assert (base_o <= base_i);
  end

endmodule

// File: rtl/fbu_word_order.sv
`timescale 1ns/1ps
module fbu_word_order
  import fbu_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [2:0]        nd_i,
  input  order_e            ord_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int NBYTES = WORD_W / 8;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    logic [7:0] same_b, swap_b;
    assign same_b = word_i[8*k +: 8];
    assign swap_b = word_i[8*(NBYTES-1-k) +: 8];
    always_comb begin
      case (ord_i)
        ORD_PIX_HI:  word_o[8*k +: 8] = rev_fields(same_b, nd_i);
        ORD_BYTE_HI: word_o[8*k +: 8] = rev_fields(swap_b, nd_i);
        default:     word_o[8*k +: 8] = same_b;
      endcase
    end
  end

endmodule

// File: rtl/fbu_pix_fmt.sv
`timescale 1ns/1ps
module fbu_pix_fmt
  import fbu_pkg::*;
(
  input  logic [PIX_W-1:0] raw_i,
  input  logic [2:0]       nd_i,
  input  logic             swap_rb_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             direct_o
);
  logic [4:0] h0, h1, h2;
  logic [7:0] w0, w1, w2;

  assign h0 = raw_i[4:0];
  assign h1 = raw_i[9:5];
  assign h2 = raw_i[14:10];
  assign w0 = raw_i[7:0];
  assign w1 = raw_i[15:8];
  assign w2 = raw_i[23:16];

  always_comb begin
    direct_o = 1'b1;
    case (nd_i)
      3'd4: pix_o = swap_rb_i ? {h2, 3'b0, h1, 3'b0, h0, 3'b0}
                              : {h0, 3'b0, h1, 3'b0, h2, 3'b0};
      3'd5: pix_o = swap_rb_i ? {w2, w1, w0} : {w0, w1, w2};
      default: begin
        direct_o = 1'b0;
        pix_o    = {16'b0, w0};
      end
    endcase
  end

endmodule

// File: rtl/fb_line_unpack.sv
`timescale 1ns/1ps
module fb_line_unpack
  import fbu_pkg::*;
#(
  parameter int COL_W  = 12,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              pwr_i,
  input  logic [2:0]        depth_i,
  input  logic              swap_rb_i,
  input  logic              byte_be_i,
  input  logic              pix_be_i,
  input  logic [COL_W-1:0]  cols_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [COL_W+1:0]  line_bytes_o,
  input  logic [31:0]       word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic [23:0]       pix_o,
  output logic              pix_direct_o,
  output logic              pix_last_o,
  output logic              pix_valid_o,
  input  logic              pix_ready_i
);
  localparam logic [COL_W-1:0] COL_ONE = COL_W'(1);

  logic              on;
  logic [2:0]        nd;
  order_e            ord;
  logic [5:0]        bits, ppw;
  logic [WORD_W-1:0] ordered, mask, raw;

  logic              have_q;
  logic [WORD_W-1:0] sh_q;
  logic [5:0]        left_q;
  logic [COL_W-1:0]  col_q;

  logic line_end, word_end, pix_fire, drain, word_fire;

  assign on   = en_i & pwr_i;
  assign nd   = norm_depth(depth_i);
  assign ord  = pick_order(byte_be_i, pix_be_i);
  assign bits = bits_of(nd);
  assign ppw  = per_word(nd);

  fbu_line_geom #(.COL_W(COL_W), .ADDR_W(ADDR_W)) geom_i (
    .cols_i       (cols_i),
    .nd_i         (nd),
    .base_i       (base_i),
    .line_bytes_o (line_bytes_o),
    .base_o       (base_o)
  );

  fbu_word_order order_i (
    .word_i (word_i),
    .nd_i   (nd),
    .ord_i  (ord),
    .word_o (ordered)
  );

  assign mask = (bits == 6'd32) ? '1 : ((WORD_W'(1) << bits) - WORD_W'(1));
  assign raw  = sh_q & mask;

  fbu_pix_fmt fmt_i (
    .raw_i     (raw[PIX_W-1:0]),
    .nd_i      (nd),
    .swap_rb_i (swap_rb_i),
    .pix_o     (pix_o),
    .direct_o  (pix_direct_o)
  );

  assign line_end     = (col_q == (cols_i - COL_ONE));
  assign word_end     = (left_q == 6'd1);
  assign pix_valid_o  = on & have_q;
  assign pix_last_o   = pix_valid_o & line_end;
  assign pix_fire     = pix_valid_o & pix_ready_i;
  // word is finished when its last pixel or the line's last pixel leaves
  assign drain        = pix_fire & (line_end | word_end);
  assign word_ready_o = on & (~have_q | drain);
  assign word_fire    = word_valid_i & word_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      sh_q   <= '0;
      left_q <= '0;
      col_q  <= '0;
    end else if (!on) begin
      have_q <= 1'b0;
      left_q <= '0;
      col_q  <= '0;
    end else begin
      if (pix_fire) begin
        col_q <= line_end ? '0 : col_q + COL_ONE;
        if (!drain) begin
          sh_q   <= sh_q >> bits;
          left_q <= left_q - 6'd1;
        end
      end
      if (word_fire) begin
        sh_q   <= ordered;
        left_q <= ppw;
        have_q <= 1'b1;
      end else if (drain) begin
        have_q <= 1'b0;
      end
    end
  end

  // R9
  off_drops_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on |=> !pix_valid_o);

  // R11
  pix_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_ready_i |=> pix_valid_o || !on);

  // R12
  word_to_pix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_fire |=> pix_valid_o || !on);

  // R8
  left_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    have_q |-> left_q != 6'd0);

endmodule

// File: tb/fb_line_unpack_tb.sv
`timescale 1ns/1ps
module fb_line_unpack_tb_top;

  localparam int COL_W = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b1, pwr_i = 1'b1;
  logic [2:0] depth_i = 3'd3;
  logic swap_rb_i = 1'b0, byte_be_i = 1'b0, pix_be_i = 1'b0;
  logic [COL_W-1:0] cols_i = 12'd4;
  logic [31:0] base_i = '0, base_o;
  logic [COL_W+1:0] line_bytes_o;
  logic [31:0] word_i = '0;
  logic word_valid_i = 1'b0, word_ready_o;
  logic [23:0] pix_o;
  logic pix_direct_o, pix_last_o, pix_valid_o;
  logic pix_ready_i = 1'b1;

  always #2.5 clk = ~clk;

  fb_line_unpack #(.COL_W(COL_W), .ADDR_W(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .pwr_i(pwr_i),
    .depth_i(depth_i), .swap_rb_i(swap_rb_i), .byte_be_i(byte_be_i),
    .pix_be_i(pix_be_i), .cols_i(cols_i), .base_i(base_i), .base_o(base_o),
    .line_bytes_o(line_bytes_o), .word_i(word_i), .word_valid_i(word_valid_i),
    .word_ready_o(word_ready_o), .pix_o(pix_o), .pix_direct_o(pix_direct_o),
    .pix_last_o(pix_last_o), .pix_valid_o(pix_valid_o), .pix_ready_i(pix_ready_i)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  // monitor: sample between edges, record pixels that leave at the next edge
  logic [23:0] got_pix [64];
  logic        got_last [64];
  logic        got_dir [64];
  int          got_cyc [64];
  int          got_n = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always begin
    @(negedge clk);
    #1;
    if (pix_valid_o && pix_ready_i && got_n < 64) begin
      got_pix[got_n]  = pix_o;
      got_last[got_n] = pix_last_o;
      got_dir[got_n]  = pix_direct_o;
      got_cyc[got_n]  = cyc;
      got_n = got_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // call at a negedge; returns at the negedge after acceptance
  task automatic send_word(input logic [31:0] w);
    bit acc;
    word_valid_i = 1'b1;
    word_i = w;
    do begin
      #1;
      acc = word_ready_o;
      @(negedge clk);
    end while (!acc);
    word_valid_i = 1'b0;
  endtask

  // pixels per word from R1
  function automatic int ppw_of(input logic [2:0] d);
    case (d)
      3'd0: return 32;
      3'd1: return 16;
      3'd2: return 8;
      3'd4: return 2;
      3'd5: return 1;
      default: return 4;
    endcase
  endfunction

  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  d;
    logic        bbe;
    logic        pbe;
    logic        swp;
    logic [31:0] w;
    logic [23:0] e0;
    logic [23:0] e1;
    logic        dir;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{8'd3, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0002, 24'h0,      24'h1,      1'b0},
    '{8'd4, 3'd0, 1'b0, 1'b1, 1'b0, 32'h0000_0080, 24'h1,      24'h0,      1'b0},
    '{8'd5, 3'd0, 1'b1, 1'b0, 1'b0, 32'h4000_0000, 24'h0,      24'h1,      1'b0},
    '{8'd3, 3'd1, 1'b0, 1'b0, 1'b0, 32'h0000_001B, 24'h3,      24'h2,      1'b0},
    '{8'd4, 3'd1, 1'b0, 1'b1, 1'b0, 32'h0000_001B, 24'h0,      24'h1,      1'b0},
    '{8'd3, 3'd2, 1'b0, 1'b0, 1'b0, 32'h0000_00A5, 24'h5,      24'hA,      1'b0},
    '{8'd4, 3'd2, 1'b0, 1'b1, 1'b0, 32'h0000_00A5, 24'hA,      24'h5,      1'b0},
    '{8'd5, 3'd2, 1'b1, 1'b1, 1'b0, 32'hC300_0000, 24'hC,      24'h3,      1'b0},
    '{8'd3, 3'd3, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 24'h78,     24'h56,     1'b0},
    '{8'd4, 3'd3, 1'b0, 1'b1, 1'b0, 32'h1234_5678, 24'h78,     24'h56,     1'b0},
    '{8'd5, 3'd3, 1'b1, 1'b0, 1'b0, 32'h1234_5678, 24'h12,     24'h34,     1'b0},
    '{8'd1, 3'd6, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 24'h78,     24'h56,     1'b0},
    '{8'd1, 3'd7, 1'b1, 1'b0, 1'b0, 32'h1234_5678, 24'h12,     24'h34,     1'b0},
    '{8'd6, 3'd4, 1'b0, 1'b0, 1'b0, 32'h0C01_03E0, 24'h00F800, 24'h080018, 1'b1},
    '{8'd6, 3'd4, 1'b0, 1'b0, 1'b1, 32'h0C01_03E0, 24'h00F800, 24'h180008, 1'b1},
    '{8'd6, 3'd4, 1'b1, 1'b0, 1'b0, 32'h0C01_03E0, 24'h604000, 24'h1800C0, 1'b1},
    '{8'd7, 3'd5, 1'b0, 1'b0, 1'b0, 32'hFF11_2233, 24'h332211, 24'h0,      1'b1},
    '{8'd7, 3'd5, 1'b0, 1'b0, 1'b1, 32'hFF11_2233, 24'h112233, 24'h0,      1'b1},
    '{8'd7, 3'd5, 1'b1, 1'b0, 1'b0, 32'hFF11_2233, 24'hFF1122, 24'h0,      1'b1}
  };

  initial begin : watchdog
    #500us;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    cycles(3);
    rst_ni = 1'b1;
    cycles(1);
    #1;
    // reset state
    chk("R9 reset valid", 32'(pix_valid_o), 32'd0);
    chk("R9 reset ready", 32'(word_ready_o), 32'd1);
    chk("R8 reset last", 32'(pix_last_o), 32'd0);
    @(negedge clk);

    // R3 R4 R5 R6 R7 R1: table walk, one word per line
    for (int v = 0; v < NV; v++) begin
      int n;
      string tag;
      depth_i = VECS[v].d;
      byte_be_i = VECS[v].bbe;
      pix_be_i = VECS[v].pbe;
      swap_rb_i = VECS[v].swp;
      n = ppw_of(VECS[v].d);
      cols_i = COL_W'(n);
      got_n = 0;
      send_word(VECS[v].w);
      cycles(n + 3);
      tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
      chk({tag, " count"}, 32'(got_n), 32'(n));
      chk({tag, " pix0"}, 32'(got_pix[0]), 32'(VECS[v].e0));
      if (n > 1) begin
        chk({tag, " pix1"}, 32'(got_pix[1]), 32'(VECS[v].e1));
        chk({tag, " last0"}, 32'(got_last[0]), 32'd0);
      end
      chk({tag, " direct"}, 32'(got_dir[0]), 32'(VECS[v].dir));
      chk({tag, " R8 last"}, 32'(got_last[n-1]), 32'd1);
    end
    byte_be_i = 1'b0; pix_be_i = 1'b0; swap_rb_i = 1'b0;

    // R2 line bytes at 64 columns
    cols_i = 12'd64;
    for (int d = 0; d < 8; d++) begin
      logic [31:0] exp;
      case (d)
        0: exp = 8; 1: exp = 16; 2: exp = 32; 4: exp = 128; 5: exp = 256;
        default: exp = 64;
      endcase
      depth_i = 3'(d);
      #1;
      chk($sformatf("R2 depth%0d", d), 32'(line_bytes_o), exp);
      @(negedge clk);
    end
    cols_i = 12'd100;
    depth_i = 3'd0;
    #1;
    chk("R2 truncate", 32'(line_bytes_o), 32'd12);
    @(negedge clk);

    // R10 base alias
    base_i = 32'h8000_0000; #1; chk("R10 edge", base_o, 32'h8000_0000);
    base_i = 32'h8000_0004; #1; chk("R10 above", base_o, 32'h0000_0004);
    base_i = 32'h0000_1000; #1; chk("R10 below", base_o, 32'h0000_1000);
    base_i = 32'hFFFF_FFFF; #1; chk("R10 top", base_o, 32'h7FFF_FFFF);
    @(negedge clk);

    // R8 partial final word, next line starts on next word
    depth_i = 3'd3;
    cols_i = 12'd10;
    got_n = 0;
    send_word(32'h0302_0100);
    send_word(32'h0706_0504);
    send_word(32'h0B0A_0908);
    send_word(32'h1312_1110);
    send_word(32'h1716_1514);
    send_word(32'h1B1A_1918);
    cycles(6);
    chk("R8 total", 32'(got_n), 32'd20);
    chk("R8 pix9", 32'(got_pix[9]), 32'h09);
    chk("R8 last9", 32'(got_last[9]), 32'd1);
    chk("R8 last8", 32'(got_last[8]), 32'd0);
    chk("R8 line2 first", 32'(got_pix[10]), 32'h10);
    chk("R8 pix19", 32'(got_pix[19]), 32'h19);
    chk("R8 last19", 32'(got_last[19]), 32'd1);
    chk("R12 8bpp span", 32'(got_cyc[19] - got_cyc[0]), 32'd19);

    // R12 32 bits per pixel, one word per pixel, no gap
    depth_i = 3'd5;
    cols_i = 12'd4;
    got_n = 0;
    send_word(32'h0000_0001);
    send_word(32'h0000_0002);
    send_word(32'h0000_0003);
    send_word(32'h0000_0004);
    cycles(4);
    chk("R12 count", 32'(got_n), 32'd4);
    chk("R12 span", 32'(got_cyc[3] - got_cyc[0]), 32'd3);
    chk("R12 pix3", 32'(got_pix[3]), 32'h04_0000);

    // R11 back-pressure
    depth_i = 3'd3;
    cols_i = 12'd4;
    pix_ready_i = 1'b0;
    got_n = 0;
    send_word(32'hA3A2_A1A0);
    word_valid_i = 1'b1;
    word_i = 32'hDEAD_BEEF;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R11 valid held", 32'(pix_valid_o), 32'd1);
      chk("R11 pix held", 32'(pix_o), 32'hA0);
      chk("R11 no accept", 32'(word_ready_o), 32'd0);
      @(negedge clk);
    end
    word_valid_i = 1'b0;
    pix_ready_i = 1'b1;
    cycles(6);
    chk("R11 count", 32'(got_n), 32'd4);
    chk("R11 pix0", 32'(got_pix[0]), 32'hA0);
    chk("R11 pix3", 32'(got_pix[3]), 32'hA3);

    // R9 power drop while a pixel is held
    cols_i = 12'd8;
    pix_ready_i = 1'b0;
    got_n = 0;
    send_word(32'h4433_2211);
    #1;
    chk("R9 pending", 32'(pix_o), 32'h11);
    @(negedge clk);
    pwr_i = 1'b0;
    word_valid_i = 1'b1;
    word_i = 32'hDEAD_BEEF;
    #1;
    chk("R9 pwr off ready", 32'(word_ready_o), 32'd0);
    chk("R9 pwr off valid", 32'(pix_valid_o), 32'd0);
    cycles(2);
    pwr_i = 1'b1;
    en_i = 1'b0;
    #1;
    chk("R9 en off ready", 32'(word_ready_o), 32'd0);
    chk("R9 en off valid", 32'(pix_valid_o), 32'd0);
    @(negedge clk);
    word_valid_i = 1'b0;
    en_i = 1'b1;
    #1;
    chk("R9 dropped", 32'(pix_valid_o), 32'd0);
    @(negedge clk);
    pix_ready_i = 1'b1;
    got_n = 0;
    send_word(32'h8877_6655);
    send_word(32'hCCBB_AA99);
    cycles(6);
    chk("R9 restart count", 32'(got_n), 32'd8);
    chk("R9 restart pix0", 32'(got_pix[0]), 32'h55);
    chk("R9 restart last", 32'(got_last[7]), 32'd1);
    chk("R9 restart pix7", 32'(got_pix[7]), 32'hCC);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule